// File: doc/BRIEF.md
# Single-Operand Compare-And-Swap Unit

This unit performs an atomic compare-and-swap on one memory operand for a small in-order core. The core presents a decoded opcode word, an extension word and a computed effective address, and pulses `start_i`. The unit names two entries of the core's eight-entry data register file: the compare register and the update register. It reads their contents in the start cycle. It then runs a locked read on a simple request/acknowledge memory bus. It writes the update value back only when the loaded operand equals the compare operand.

When the operation finishes, the unit pulses `done_o`. Alongside that pulse it presents:
- the condition flags of the comparison;
- the index of the compare register;
- the new value of the compare register, for the core to write back.

A misaligned address or an illegal size code produces a one-cycle `fault_o` pulse instead, and the bus is not touched. Byte, word and long operands are supported. Bus data is right-justified. For byte and word reads, the bits above the operand are ignored.

Top module: `cas_unit`

## Requirements
- R1: Opcode bits 10:9 select the operand size: 1 is byte, 2 is word, 3 is long. `bus_size_o` carries that same code on every request. Code 0 is rejected: `fault_o` pulses and the bus is not used.
- R2: Extension bits 2:0 drive `rf_cmp_idx_o`, and extension bits 8:6 drive `rf_upd_idx_o`. `res_idx_o` returns the compare index with the result.
- R3: A word access with address bit 0 set, or a long access with either of address bits 1:0 set, raises `fault_o` for exactly the one cycle after `start_i` is sampled. No bus request is made in that cycle or later. Byte accesses may use any address.
- R4: The read request and any following write request have `bus_lock_o` high. The lock stays high without a gap from the first read cycle to the write acknowledge.
- R5: When the loaded operand equals the compare operand at the operand size, exactly one write goes to the same address. Its data is the update register's low bits at that size, with zeros above. When the operands differ, no write request is made.
- R6: `flags_o` = {N,Z,V,C} are the flags of loaded minus compare, taken at the operand size with both operands sign-extended. N is the sign of the difference. Z means the two are equal. V is signed overflow. C is the unsigned borrow.
- R7: `res_value_o` is the compare register with its low 8 bits (byte) or low 16 bits (word) replaced by the loaded operand, and its upper bits kept. A long operand replaces all 32 bits.
- R8: `done_o` is a single-cycle pulse in the cycle after the last bus acknowledge. `flags_o`, `res_idx_o` and `res_value_o` are valid during that pulse.
- R9: `start_i` is ignored while an operation is in progress. The address, size and number of bus cycles of the running operation do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (sampled when idle) |
| opcode_i | input | 16 | Opcode word; bits 10:9 give the size |
| ext_i | input | 16 | Extension word; register index fields |
| ea_i | input | AW | Effective address of the operand |
| rf_cmp_idx_o | output | 3 | Compare register read index |
| rf_cmp_data_i | input | 32 | Compare register contents |
| rf_upd_idx_o | output | 3 | Update register read index |
| rf_upd_data_i | input | 32 | Update register contents |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | Write when high, read when low |
| bus_lock_o | output | 1 | Locks the bus against other masters |
| bus_size_o | output | 2 | Access size code (as in R1) |
| bus_addr_o | output | AW | Access address |
| bus_wdata_o | output | 32 | Right-justified write data |
| bus_rdata_i | input | 32 | Right-justified read data |
| bus_ack_i | input | 1 | Completes the current request |
| done_o | output | 1 | Operation complete pulse |
| fault_o | output | 1 | Alignment or size fault pulse |
| flags_o | output | 4 | {N,Z,V,C} of the comparison |
| res_idx_o | output | 3 | Compare register index for writeback |
| res_value_o | output | 32 | New compare register value |

## Verification
The assertions check, on every cycle, the rules that hold regardless of data:
- every request is aligned and carries a legal size code;
- a write is locked, is preceded by the lock, and only follows a match;
- a fault never coexists with bus traffic;
- `done_o` only ever follows an acknowledge.

Only the bench's scenarios can show that the arithmetic is right. That covers the flag values for borrow and overflow cases, the partial-register merge, which register indices are used, the write data, and that a start pulse during a busy operation leaves it unchanged. The bench shows these by comparing against values it computes itself from mixed-latency bus responses.

// File: rtl/cas_pkg.sv
package cas_pkg;

  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_BYTE = 2'd1,
    SZ_WORD = 2'd2,
    SZ_LONG = 2'd3
  } opsz_e;

  // alignment rule per operand size
  function automatic logic misaligned(input logic [1:0] lo, input opsz_e sz);
    case (sz)
      SZ_WORD: misaligned = lo[0];
      SZ_LONG: misaligned = |lo;
      default: misaligned = 1'b0;
    endcase
  endfunction

  // left shift that moves the operand sign bit to the word MSB
  function automatic logic [4:0] msb_shift(input opsz_e sz);
    case (sz)
      SZ_BYTE: msb_shift = 5'd24;
      SZ_WORD: msb_shift = 5'd16;
      default: msb_shift = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/cas_decode.sv
module cas_decode
  import cas_pkg::*;
(
  input  logic [1:0] size_code_i,
  input  logic [1:0] addr_lo_i,
  output opsz_e      size_o,
  output logic       reject_o
);

  always_comb begin
    size_o   = opsz_e'(size_code_i);
    reject_o = (size_o == SZ_NONE) || misaligned(addr_lo_i, size_o);
  end

endmodule

// File: rtl/cas_cmp.sv
module cas_cmp
  import cas_pkg::*;
(
  input  logic [DATA_W-1:0] load_i,
  input  logic [DATA_W-1:0] cmp_i,
  input  opsz_e             size_i,
  output logic [3:0]        nzvc_o,
  output logic              match_o,
  output logic [DATA_W-1:0] merged_o
);

  logic [4:0]        sh;
  logic [DATA_W-1:0] a_top;
  logic [DATA_W-1:0] b_top;
  logic [DATA_W:0]   diff;

  always_comb begin
    sh    = msb_shift(size_i);
    a_top = load_i << sh;
    b_top = cmp_i << sh;
    diff  = {1'b0, a_top} - {1'b0, b_top};
    match_o = (a_top == b_top);
    nzvc_o[3] = diff[DATA_W-1];
    nzvc_o[2] = (diff[DATA_W-1:0] == '0);
    nzvc_o[1] = (a_top[DATA_W-1] ^ b_top[DATA_W-1]) & (diff[DATA_W-1] ^ a_top[DATA_W-1]);
    nzvc_o[0] = diff[DATA_W];
    case (size_i)
      SZ_BYTE: merged_o = {cmp_i[DATA_W-1:8], load_i[7:0]};
      SZ_WORD: merged_o = {cmp_i[DATA_W-1:16], load_i[15:0]};
      default: merged_o = load_i;
    endcase
  end

endmodule

// File: rtl/cas_ctrl.sv
module cas_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic reject_i,
  input  logic ack_i,
  input  logic match_i,
  output logic accept_o,
  output logic rd_o,
  output logic wr_o,
  output logic fin_o,
  output logic flt_o
);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_FIN, S_FLT} st_e;
  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: if (start_i) st_d = reject_i ? S_FLT : S_RD;
      S_RD:   if (ack_i)   st_d = match_i ? S_WR : S_FIN;
      S_WR:   if (ack_i)   st_d = S_FIN;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign accept_o = (st_q == S_IDLE) && start_i && !reject_i;
  assign rd_o     = (st_q == S_RD);
  assign wr_o     = (st_q == S_WR);
  assign fin_o    = (st_q == S_FIN);
  assign flt_o    = (st_q == S_FLT);

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WR) && !$past(st_q == S_WR) |-> $past(st_q == S_RD)); // R4

endmodule

// File: rtl/cas_unit.sv
module cas_unit
  import cas_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [15:0]       opcode_i,
  input  logic [15:0]       ext_i,
  input  logic [AW-1:0]     ea_i,
  output logic [2:0]        rf_cmp_idx_o,
  input  logic [31:0]       rf_cmp_data_i,
  output logic [2:0]        rf_upd_idx_o,
  input  logic [31:0]       rf_upd_data_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic              bus_lock_o,
  output logic [1:0]        bus_size_o,
  output logic [AW-1:0]     bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  input  logic [31:0]       bus_rdata_i,
  input  logic              bus_ack_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [3:0]        flags_o,
  output logic [2:0]        res_idx_o,
  output logic [31:0]       res_value_o
);

  localparam int unsigned DW = DATA_W;

  logic unused_fields;
  assign unused_fields = ^{opcode_i[15:11], opcode_i[8:0], ext_i[15:9], ext_i[5:3]};

  opsz_e   dec_size;
  logic    dec_reject;
  logic    accept, rd, wr, fin, flt;
  logic [3:0]    cmp_nzvc;
  logic          cmp_match;
  logic [DW-1:0] cmp_merged;

  opsz_e         size_q;
  logic [AW-1:0] addr_q;
  logic [2:0]    cidx_q;
  logic [DW-1:0] cval_q, uval_q;
  logic [3:0]    flags_q;
  logic [DW-1:0] res_q;
  logic          rd_cap;

  assign rf_cmp_idx_o = ext_i[2:0];
  assign rf_upd_idx_o = ext_i[8:6];

  cas_decode u_dec (
    .size_code_i (opcode_i[10:9]),
    .addr_lo_i   (ea_i[1:0]),
    .size_o      (dec_size),
    .reject_o    (dec_reject)
  );

  cas_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .reject_i (dec_reject),
    .ack_i    (bus_ack_i),
    .match_i  (cmp_match),
    .accept_o (accept),
    .rd_o     (rd),
    .wr_o     (wr),
    .fin_o    (fin),
    .flt_o    (flt)
  );

  cas_cmp u_cmp (
    .load_i   (bus_rdata_i),
    .cmp_i    (cval_q),
    .size_i   (size_q),
    .nzvc_o   (cmp_nzvc),
    .match_o  (cmp_match),
    .merged_o (cmp_merged)
  );

  assign rd_cap = rd && bus_ack_i;

  // operand capture, enabled on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= SZ_NONE;
      addr_q <= '0;
      cidx_q <= '0;
      cval_q <= '0;
      uval_q <= '0;
    end else if (accept) begin
      size_q <= dec_size;
      addr_q <= ea_i;
      cidx_q <= ext_i[2:0];
      cval_q <= rf_cmp_data_i;
      uval_q <= rf_upd_data_i;
    end
  end

  // result capture, enabled on read acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      res_q   <= '0;
    end else if (rd_cap) begin
      flags_q <= cmp_nzvc;
      res_q   <= cmp_merged;
    end
  end

  always_comb begin
    case (size_q)
      SZ_BYTE: bus_wdata_o = {24'd0, uval_q[7:0]};
      SZ_WORD: bus_wdata_o = {16'd0, uval_q[15:0]};
      default: bus_wdata_o = uval_q;
    endcase
  end

  assign bus_req_o   = rd | wr;
  assign bus_we_o    = wr;
  assign bus_lock_o  = rd | wr;
  assign bus_size_o  = size_q;
  assign bus_addr_o  = addr_q;
  assign done_o      = fin;
  assign fault_o     = flt;
  assign flags_o     = flags_q;
  assign res_idx_o   = cidx_q;
  assign res_value_o = res_q;

  AST_LEGAL_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> (bus_size_o != 2'd0)); // R1
  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> !misaligned(bus_addr_o[1:0], opsz_e'(bus_size_o))); // R3
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !bus_req_o && !$past(bus_req_o)); // R3
  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_we_o) |-> bus_lock_o && $past(bus_lock_o)); // R4
  AST_WRITE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_we_o) |-> flags_q[2]); // R5
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(bus_req_o && bus_ack_i)); // R8
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, fault_o, bus_req_o})); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && $past(bus_req_o)) |-> $stable(bus_addr_o)); // R9

endmodule

// File: tb/cas_unit_tb_top.sv
`timescale 1ns/1ps
module cas_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] opcode = '0;
  logic [15:0] ext = '0;
  logic [31:0] ea = '0;
  logic [2:0]  rf_cmp_idx, rf_upd_idx;
  logic [31:0] rf_cmp_data, rf_upd_data;
  logic        bus_req, bus_we, bus_lock, bus_ack;
  logic [1:0]  bus_size;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        done, fault;
  logic [3:0]  flags;
  logic [2:0]  res_idx;
  logic [31:0] res_value;

  logic [31:0] rf [8];
  logic [31:0] mem [64];
  int          lat = 0;
  int          wcnt;
  int          writes;
  logic        pre_en = 1'b0;
  logic [5:0]  pre_addr = '0;
  logic [31:0] pre_val = '0;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  assign rf_cmp_data = rf[rf_cmp_idx];
  assign rf_upd_data = rf[rf_upd_idx];
  assign bus_rdata   = mem[bus_addr[5:0]];

  cas_unit #(.AW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .opcode_i(opcode), .ext_i(ext), .ea_i(ea),
    .rf_cmp_idx_o(rf_cmp_idx), .rf_cmp_data_i(rf_cmp_data),
    .rf_upd_idx_o(rf_upd_idx), .rf_upd_data_i(rf_upd_data),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_lock_o(bus_lock), .bus_size_o(bus_size),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack),
    .done_o(done), .fault_o(fault), .flags_o(flags), .res_idx_o(res_idx), .res_value_o(res_value)
  );

  // memory responder with programmable wait states
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack <= 1'b0;
      wcnt    <= 0;
      writes  <= 0;
    end else begin
      if (pre_en) mem[pre_addr] <= pre_val;
      if (bus_req && !bus_ack) begin
        if (wcnt >= lat) begin
          bus_ack <= 1'b1;
          wcnt    <= 0;
        end else wcnt <= wcnt + 1;
      end else begin
        bus_ack <= 1'b0;
        if (bus_req && bus_ack && bus_we) begin
          mem[bus_addr[5:0]] <= bus_wdata;
          writes <= writes + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic longint sext(input logic [31:0] v, input int w);
    longint x;
    x = longint'(v) & ((64'd1 << w) - 1);
    if (x >= (64'sd1 <<< (w - 1))) x = x - (64'sd1 <<< w);
    return x;
  endfunction

  task automatic run_op(input logic [1:0] szc, input logic [31:0] a, input logic [2:0] ci,
                        input logic [2:0] ui, input logic [31:0] cv, input logic [31:0] uv,
                        input logic [31:0] mv, input int latency, input bit poke);
    int w;
    longint la, cb, diff, mask;
    bit match, seen_done, prev_ack;
    logic [3:0] exp_f;
    logic [31:0] exp_res, exp_wd, exp_mem;
    int w0;
    w = (szc == 2'd1) ? 8 : (szc == 2'd2) ? 16 : 32;
    mask = (64'd1 << w) - 1;
    la = sext(mv, w);
    cb = sext(cv, w);
    match = (la == cb);
    diff = la - cb;
    exp_f[3] = diff[w-1];
    exp_f[2] = match;
    exp_f[1] = (diff > ((64'sd1 <<< (w - 1)) - 1)) || (diff < -(64'sd1 <<< (w - 1)));
    exp_f[0] = ((longint'(mv) & mask) < (longint'(cv) & mask));
    exp_res = (w == 32) ? mv : ((cv & ~32'(mask)) | (mv & 32'(mask)));
    exp_wd  = uv & 32'(mask);
    exp_mem = match ? exp_wd : mv;
    rf[ci] = cv;
    rf[ui] = uv;
    lat = latency;
    @(negedge clk);
    pre_en = 1'b1; pre_addr = a[5:0]; pre_val = mv;
    @(negedge clk);
    pre_en = 1'b0;
    w0 = writes;
    start = 1'b1;
    opcode = {5'b01001, szc, 9'b011000111};
    ext = {7'b1010101, ui, 3'b101, ci};
    ea = a;
    @(negedge clk);
    start = 1'b0;
    seen_done = 1'b0;
    prev_ack = 1'b0;
    for (int cyc = 0; cyc < 60 && !seen_done; cyc++) begin
      if (poke && cyc == 0) begin
        start = 1'b1; ea = 32'h3C; opcode = {5'b0, 2'd3, 9'b0};
      end else if (poke && cyc == 1) start = 1'b0;
      chk(!fault, "R3", "unexpected fault", {31'd0, fault}, 32'd0);
      if (bus_req) begin
        chk(bus_addr == a, "R9", "bus address", bus_addr, a);
        chk(bus_size == szc, "R1", "bus size", {30'd0, bus_size}, {30'd0, szc});
        chk(bus_lock, "R4", "lock during access", {31'd0, bus_lock}, 32'd1);
        if (bus_we) begin
          chk(match, "R5", "write on mismatch", 32'd1, 32'd0);
          chk(bus_wdata == exp_wd, "R5", "write data", bus_wdata, exp_wd);
        end
      end
      if (done) begin
        seen_done = 1'b1;
        chk(prev_ack, "R8", "done not after ack", {31'd0, prev_ack}, 32'd1);
        chk(flags == exp_f, "R6", "flags NZVC", {28'd0, flags}, {28'd0, exp_f});
        chk(res_value == exp_res, "R7", "result value", res_value, exp_res);
        chk(res_idx == ci, "R2", "result index", {29'd0, res_idx}, {29'd0, ci});
      end
      prev_ack = bus_req && bus_ack;
      if (!seen_done) @(negedge clk);
    end
    chk(seen_done, "R8", "done seen", {31'd0, seen_done}, 32'd1);
    @(negedge clk);
    chk(!done, "R8", "done one cycle", {31'd0, done}, 32'd0);
    chk(!bus_req, "R9", "no extra access", {31'd0, bus_req}, 32'd0);
    chk((writes - w0) == (match ? 1 : 0), "R5", "write count",
        32'(writes - w0), match ? 32'd1 : 32'd0);
    chk(mem[a[5:0]] == exp_mem, "R5", "memory after", mem[a[5:0]], exp_mem);
    @(negedge clk);
    chk(!bus_req && !done, "R9", "idle after op", {30'd0, bus_req, done}, 32'd0);
  endtask

  task automatic run_fault(input logic [1:0] szc, input logic [31:0] a, input string req);
    @(negedge clk);
    start = 1'b1;
    opcode = {5'b01001, szc, 9'b011000111};
    ext = 16'h0041;
    ea = a;
    @(negedge clk);
    start = 1'b0;
    chk(fault, req, "fault pulse", {31'd0, fault}, 32'd1);
    chk(!bus_req, req, "no bus on fault", {31'd0, bus_req}, 32'd0);
    @(negedge clk);
    chk(!fault, req, "fault one cycle", {31'd0, fault}, 32'd0);
    chk(!bus_req && !done, req, "quiet after fault", {30'd0, bus_req, done}, 32'd0);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) rf[i] = 32'h0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && !bus_lock && !done && !fault, "R8", "reset state",
        {28'd0, bus_req, bus_lock, done, fault}, 32'd0);
    // byte match, garbage above the byte in memory (R1 R5 R7)
    run_op(2'd1, 32'h10, 3'd5, 3'd2, 32'h1234_5680, 32'hAAAA_AA5C, 32'hDEAD_BE80, 0, 1'b0);
    // byte mismatch with signed overflow, odd address (R6)
    run_op(2'd1, 32'h11, 3'd0, 3'd7, 32'h0000_0001, 32'h0000_0099, 32'h0000_0080, 2, 1'b0);
    // word match, compare sign bits above word differ (R6 R7)
    run_op(2'd2, 32'h22, 3'd3, 3'd4, 32'hFFFF_8001, 32'h1111_2222, 32'h0000_8001, 1, 1'b0);
    // word mismatch with borrow
    run_op(2'd2, 32'h24, 3'd6, 3'd1, 32'hABCD_0002, 32'h0000_7777, 32'h5555_0001, 0, 1'b0);
    // long match
    run_op(2'd3, 32'h30, 3'd1, 3'd6, 32'hCAFE_F00D, 32'h0BAD_BEEF, 32'hCAFE_F00D, 3, 1'b0);
    // long mismatch, signed overflow and borrow
    run_op(2'd3, 32'h34, 3'd2, 3'd3, 32'hFFFF_FFFF, 32'h1234_5678, 32'h7FFF_FFFF, 1, 1'b0);
    // faults (R3 R1)
    run_fault(2'd2, 32'h13, "R3");
    run_fault(2'd3, 32'h32, "R3");
    run_fault(2'd0, 32'h20, "R1");
    // start pulsed while busy (R9)
    run_op(2'd3, 32'h38, 3'd4, 3'd0, 32'h0000_0042, 32'h8000_0000, 32'h0000_0042, 2, 1'b1);
    // byte mismatch, equal low bits compare not triggered
    run_op(2'd1, 32'h05, 3'd7, 3'd5, 32'hFFFF_FF7F, 32'h0000_0011, 32'h0000_00FF, 0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule